// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM array. After reset it counts out the power-up settling time. It then runs a fixed number of warm-up refresh cycles and reports that the array is ready. From then on it keeps the array refreshed by spreading refresh cycles evenly over the retention window.

Every refresh is a CAS-before-RAS cycle, so the array supplies the row address internally and no address output is needed. The write-enable strobe stays high throughout, because pulling it low in that sequence would put the array into test mode. The block shares the strobes with the normal access path. It therefore raises a request to an arbiter and waits for the grant before it drives anything.

A refresh can be held off by a long page burst. In that case the block counts the due refreshes, up to a limit. When the grant arrives it issues them back to back. All timing values are given in nanoseconds and converted to clock counts from the clock period.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, `req` and the strobes stay inactive until `req` first rises at the rising edge numbered STARTUP_CYC+1. STARTUP_CYC is the start-up time divided by the clock period, rounded up, and is 10000 at the defaults.
- R2: Exactly WARM_CYCLES refresh cycles (8 at the defaults) complete before `ready` rises. `ready` rises when the last of them finishes its precharge.
- R3: Once `ready` is high, it stays high until reset.
- R4: Each refresh lowers `cas_n` one cycle before `ras_n`. `ras_n` stays low for RAS_LEN cycles (3 at the defaults), and both strobes rise together.
- R5: A strobe goes low only while `req` and `grant` are both high. While `grant` is withheld, `req` stays high and both strobes stay high.
- R6: `we_n` is high at all times, so every refresh is a plain CAS-before-RAS cycle.
- R7: After each refresh both strobes stay high for at least PRE_CYC cycles (2 at the defaults). Successive falls of `cas_n` are at least TRC_CYC cycles apart (6 at the defaults).
- R8: Once the array is ready and the grant is immediate, refresh cycles start every INTERVAL_CYC cycles. INTERVAL_CYC is the retention time divided by the row count and the clock period, rounded down, and is 781 at the defaults.
- R9: Refreshes that fall due while the grant is withheld are counted, up to PEND_MAX (4 at the defaults). Further due refreshes are dropped. When the grant arrives, the counted refreshes are issued back to back.
- R10: Asserting reset at any time returns `req` and `ready` to 0 and both strobes to 1. The start-up wait then begins again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Arbiter grant of the DRAM strobes |
| req | output | 1 | Request for the strobes, held through the whole refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Array is initialised and open for normal use |

## Verification
The strobe assertions assume that the arbiter keeps `grant` high for as long as `req` is high once it has granted. They do not model a grant that is revoked in the middle of a cycle. The bench meets this assumption by forming `grant` as `req` gated with a bench-controlled enable. That enable only changes while no refresh is in flight: a few hundred cycles after a refresh interval has started, and far from the next one. With that grant model, withholding the enable for whole intervals exercises both the counted backlog and the saturated backlog.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_IDLE,
    ST_REQ,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } rfs_state_t;

  // ceiling division for converting times to clock counts
  function automatic int cdiv(longint a, longint b);
    return int'((a + b - 1) / b);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfs_tick.sv
module rfs_tick #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(CYCLES - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rfs_pend.sv
module rfs_pend #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic busy,
  output logic more
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      if (cnt != W'(MAX)) cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
  assign more = (cnt > W'(1));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfs_pkg::*;
#(
  parameter int CLK_PS       = 20000,
  parameter int STARTUP_NS   = 200000,
  parameter int RETENTION_NS = 32000000,
  parameter int ROWS         = 2048,
  parameter int TRC_NS       = 110,
  parameter int TRAS_NS      = 60,
  parameter int TRP_NS       = 40,
  parameter int WARM_CYCLES  = 8,
  parameter int PEND_MAX     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  output logic req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int STARTUP_CYC  = cdiv(longint'(STARTUP_NS) * 1000, CLK_PS);
  localparam int INTERVAL_CYC = int'((longint'(RETENTION_NS) * 1000) / ROWS / CLK_PS);
  localparam int TRC_CYC      = cdiv(longint'(TRC_NS) * 1000, CLK_PS);
  localparam int TRAS_CYC     = cdiv(longint'(TRAS_NS) * 1000, CLK_PS);
  localparam int PRE_CYC      = imax(1, cdiv(longint'(TRP_NS) * 1000, CLK_PS));
  localparam int RAS_LEN      = imax(imax(1, TRAS_CYC), TRC_CYC - 1 - PRE_CYC);
  localparam int PH_W         = $clog2(imax(RAS_LEN, PRE_CYC) + 1);
  localparam int WARM_W       = $clog2(WARM_CYCLES + 1);

  rfs_state_t        state, nxt;
  logic [PH_W-1:0]   ph;
  logic [WARM_W-1:0] warm_left;
  logic start_tick, intv_tick;
  logic pend_busy, pend_more;
  logic warm_active, done, any_work, more_work;

  rfs_tick #(.CYCLES(STARTUP_CYC)) u_start (
    .clk(clk), .rst(rst), .en(state == ST_WAIT), .tick(start_tick)
  );

  rfs_tick #(.CYCLES(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst(rst), .en(ready), .tick(intv_tick)
  );

  rfs_pend #(.MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst(rst), .inc(intv_tick), .dec(done && !warm_active),
    .busy(pend_busy), .more(pend_more)
  );

  assign warm_active = (warm_left != '0);
  assign done        = (state == ST_PRE) && (ph == PH_W'(PRE_CYC - 1));
  assign any_work    = warm_active || pend_busy;
  assign more_work   = warm_active ? ((warm_left > WARM_W'(1)) || pend_busy) : pend_more;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_WAIT: if (start_tick) nxt = ST_REQ;
      ST_IDLE: if (any_work) nxt = ST_REQ;
      ST_REQ:  if (grant) nxt = ST_CAS;
      ST_CAS:  nxt = ST_RAS;
      ST_RAS:  if (ph == PH_W'(RAS_LEN - 1)) nxt = ST_PRE;
      ST_PRE:  if (done) nxt = more_work ? ST_REQ : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT;
      ph        <= '0;
      warm_left <= WARM_W'(WARM_CYCLES);
      ready     <= 1'b0;
      req       <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
    end else begin
      state <= nxt;
      ph    <= (nxt != state) ? '0 : ph + 1'b1;
      if (done && warm_active) warm_left <= warm_left - 1'b1;
      if (done && warm_left == WARM_W'(1)) ready <= 1'b1;
      req   <= (nxt == ST_REQ) || (nxt == ST_CAS) || (nxt == ST_RAS) || (nxt == ST_PRE);
      cas_n <= !((nxt == ST_CAS) || (nxt == ST_RAS));
      ras_n <= !(nxt == ST_RAS);
      we_n  <= 1'b1;
    end
  end
endmodule

// File: rtl/rfs_check.sv
module rfs_check #(
  parameter int STARTUP_CYC = 10000
) (
  input logic clk,
  input logic rst,
  input logic grant,
  input logic req,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ready
);
  int since;

  always_ff @(posedge clk) begin
    if (rst) since <= 0;
    else if (since <= STARTUP_CYC) since <= since + 1;
  end

  assert_startup_R1: assert property (@(posedge clk) disable iff (rst)
    req |-> (since >= STARTUP_CYC));

  assert_ready_late_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (since >= STARTUP_CYC));

  assert_ready_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_rise_together_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> cas_n);

  assert_strobe_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (!cas_n || !ras_n) |-> (req && grant));

  assert_we_high_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> we_n);

  assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |=> (ras_n && cas_n));
endmodule

bind dram_refresh_seq rfs_check #(.STARTUP_CYC(STARTUP_CYC)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .req(req), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ready(ready)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
  localparam int STARTUP  = 10000;  // 200 us at 20 ns
  localparam int INTERVAL = 781;    // 32 ms / 2048 / 20 ns, rounded down
  localparam int RAS_LEN  = 3;
  localparam int PRE_CYC  = 2;
  localparam int TRC_CYC  = 6;
  localparam int WARM     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant_en = 1'b0;
  logic grant, req, ras_n, cas_n, we_n, ready;

  assign grant = req & grant_en;

  always #10 clk = ~clk;

  dram_refresh_seq dut (
    .clk(clk), .rst(rst), .grant(grant), .req(req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready)
  );

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard: expected ready level at the start of each refresh
  bit exp_q[$];
  task automatic push_exp(bit rdy, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(rdy);
  endtask

  int  cas_times[$];
  int  t_cas = 0, t_rasf = 0, t_rasr = -1000, last_cas = -1000;
  int  done_cnt = 0;
  bit  rdy_at_start = 1'b0;
  logic p_cas = 1'b1, p_ras = 1'b1, p_ready = 1'b0;

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (p_cas && !cas_n) begin
        chk(ras_n == 1'b1, "R4 ras high at cas fall", ras_n, 1);
        chk(grant && req, "R5 grant at strobe", grant, 1);
        chk(we_n == 1'b1, "R6 we_n high", we_n, 1);
        if (t_rasr > -1000) chk(cyc - t_rasr >= PRE_CYC, "R7 precharge", cyc - t_rasr, PRE_CYC);
        if (last_cas > -1000) chk(cyc - last_cas >= TRC_CYC, "R7 cycle time", cyc - last_cas, TRC_CYC);
        t_cas = cyc;
        last_cas = cyc;
        rdy_at_start = ready;
        cas_times.push_back(cyc);
      end
      if (p_ras && !ras_n) begin
        t_rasf = cyc;
        chk(cyc - t_cas == 1, "R4 cas lead", cyc - t_cas, 1);
      end
      if (!p_ras && ras_n) begin
        t_rasr = cyc;
        done_cnt++;
        chk(cas_n == 1'b1, "R4 strobes rise together", cas_n, 1);
        chk(cyc - t_rasf == RAS_LEN, "R4 ras width", cyc - t_rasf, RAS_LEN);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected refresh", done_cnt, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(rdy_at_start == e, "R2 ready at refresh", rdy_at_start, e);
        end
      end
      if (!p_ready && ready) chk(done_cnt == WARM, "R2 warm-up count", done_cnt, WARM);
      if (p_ready && !ready) chk(1'b0, "R3 ready dropped", 0, 1);
    end
    p_cas = cas_n;
    p_ras = ras_n;
    p_ready = ready;
  end

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int t_rdy;
    int base;
    grant_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(req == 1'b0, "R10 reset req", req, 0);
    chk(ras_n == 1'b1, "R10 reset ras_n", ras_n, 1);
    chk(cas_n == 1'b1, "R10 reset cas_n", cas_n, 1);
    chk(ready == 1'b0, "R10 reset ready", ready, 0);
    chk(we_n == 1'b1, "R6 reset we_n", we_n, 1);
    push_exp(1'b0, WARM);
    rst = 1'b0;
    while (!req && cyc < 2 * STARTUP) @(negedge clk);
    chk(cyc == STARTUP + 1, "R1 startup delay", cyc, STARTUP + 1);
    while (!ready && cyc < 3 * STARTUP) @(negedge clk);
    t_rdy = cyc;
    chk(ready == 1'b1, "R2 ready reached", ready, 1);

    // steady refresh with immediate grant
    push_exp(1'b1, 3);
    wait_to(t_rdy + 3 * INTERVAL + 300);
    chk(done_cnt == WARM + 3, "R8 steady count", done_cnt, WARM + 3);
    if (cas_times.size() >= WARM + 3) begin
      chk(cas_times[WARM + 1] - cas_times[WARM] == INTERVAL, "R8 spacing a",
          cas_times[WARM + 1] - cas_times[WARM], INTERVAL);
      chk(cas_times[WARM + 2] - cas_times[WARM + 1] == INTERVAL, "R8 spacing b",
          cas_times[WARM + 2] - cas_times[WARM + 1], INTERVAL);
    end

    // two refreshes held off
    grant_en = 1'b0;
    push_exp(1'b1, 2);
    wait_to(t_rdy + 5 * INTERVAL + 300);
    chk(req == 1'b1, "R5 req held without grant", req, 1);
    chk(ras_n && cas_n, "R5 strobes idle without grant", cas_n, 1);
    chk(done_cnt == WARM + 3, "R5 no refresh without grant", done_cnt, WARM + 3);
    base = done_cnt;
    grant_en = 1'b1;
    push_exp(1'b1, 1);
    wait_to(t_rdy + 5 * INTERVAL + 400);
    chk(done_cnt - base == 2, "R9 backlog of two", done_cnt - base, 2);
    wait_to(t_rdy + 6 * INTERVAL + 300);
    chk(done_cnt - base == 3, "R8 after backlog", done_cnt - base, 3);

    // six due, limited to four
    grant_en = 1'b0;
    push_exp(1'b1, 4);
    base = done_cnt;
    wait_to(t_rdy + 12 * INTERVAL + 300);
    chk(req == 1'b1, "R5 req held long", req, 1);
    chk(done_cnt == base, "R5 idle during hold", done_cnt - base, 0);
    grant_en = 1'b1;
    wait_to(t_rdy + 12 * INTERVAL + 400);
    chk(done_cnt - base == 4, "R9 saturated backlog", done_cnt - base, 4);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    // reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(req == 1'b0, "R10 req after reset", req, 0);
    chk(ready == 1'b0, "R10 ready after reset", ready, 0);
    chk(ras_n && cas_n, "R10 strobes after reset", cas_n, 1);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk(req == 1'b0, "R1 wait restarts", req, 0);
    chk(ready == 1'b0, "R10 ready stays low", ready, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end
endmodule